// File: doc/BRIEF.md
# Tunable-Accuracy Multiply Unit

This block executes the four integer multiply instructions of a 32-bit core: the low product word and the three high-word variants (signed by signed, signed by unsigned, unsigned by unsigned). It sits beside the ALU in the execute stage. The pipeline presents the instruction fields and both source operands, and then stalls while the unit reports busy. The unit captures the operands when it accepts an operation. It counts a fixed number of cycles and then loads the result register as busy drops.

A 32-bit control word, supplied by the unit's own control register, can switch on an approximate reduction of the lowest partial-product columns. A column whose mask bit is set is summed exactly. A column whose mask bit is clear is reduced to the OR of its partial-product bits, so any carries that column would produce are lost. Software trades accuracy against switching activity at run time by changing the number of set mask bits. With approximation off, the result is the exact product.

Top module: `approx_mul_unit`

## Requirements
- R1: After reset, `busy` is 0 and `result` is 0.
- R2: An operation is accepted only when `opcode` is 7'b0110011, `funct7` is 7'b0000001, `funct3` is 0 to 3, and `busy` is 0. Any other code, including `funct3` 4 to 7, leaves `busy` at 0 and `result` unchanged.
- R3: `funct3` = 0 returns bits 31:0 of the product of `rs1` and `rs2`.
- R4: `funct3` = 1 returns bits 63:32 of the product of both operands taken as signed.
- R5: `funct3` = 2 returns bits 63:32 of signed `rs1` times unsigned `rs2`.
- R6: `funct3` = 3 returns bits 63:32 of the unsigned product.
- R7: `busy` rises in the cycle after acceptance and stays high for exactly LATENCY cycles. `result` takes the new value in the same cycle that `busy` falls.
- R8: `result` does not change while `busy` is high, nor while the unit is idle.
- R9: Operands, operation and control word are captured at acceptance. Changes to `rs1`, `rs2`, `ctrl_word` or the instruction fields while busy have no effect, and a multiply presented while busy is dropped.
- R10: Approximation is active only when `ctrl_word[0]` is 1 and `ctrl_word[2:1]` is 2'b00. Any other setting of these bits gives the exact product.
- R11: When approximation is active, `ctrl_word[16+j]` is the mask bit for product column j, for j below APPROX_COLS. Each column j whose mask bit is clear lowers the 64-bit product by (number of ones among rs1[i]&rs2[j-i], for i from 0 to j, minus their OR) times 2^j. The requested word is then taken from the lowered product. For example, 3*3 with all mask bits clear gives 7.
- R12: With approximation active and every mask bit set, the result equals the exact product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 7 | Instruction opcode field |
| funct3 | input | 3 | Instruction primary function field |
| funct7 | input | 7 | Instruction secondary function field |
| ctrl_word | input | 32 | Unit control register: enable, circuit select, column mask |
| pc | input | 32 | Program counter of the instruction (not used in the arithmetic) |
| rs1 | input | 32 | First source operand |
| rs2 | input | 32 | Second source operand |
| busy | output | 1 | High while an operation is in progress |
| result | output | 32 | Last completed result |

## Verification
The bench builds the unit with LATENCY = 4 and APPROX_COLS = 6. A four-cycle busy window leaves room to change operands, control word and instruction fields in the middle of an operation, and to present a second multiply that must be dropped. Six columns keep the reference loop small, yet they reach column carries of up to five bits. With them the bench can compare an all-clear mask, a partial mask and a full mask against one another and against the exact product.

// File: rtl/amu_pkg.sv
package amu_pkg;

    typedef enum logic [1:0] {
        OP_LO    = 2'd0,
        OP_HI_SS = 2'd1,
        OP_HI_SU = 2'd2,
        OP_HI_UU = 2'd3
    } mul_op_e;

    localparam logic [6:0] OPC_REG_ARITH = 7'b0110011;
    localparam logic [6:0] F7_MULDIV     = 7'b0000001;

endpackage

// File: rtl/amu_decode.sv
module amu_decode
    import amu_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic [6:0] funct7,
    output logic       hit,
    output mul_op_e    op
);
    always_comb begin
        hit = (opcode == OPC_REG_ARITH) && (funct7 == F7_MULDIV) && !funct3[2];
        op  = mul_op_e'(funct3[1:0]);
    end
endmodule

// File: rtl/amu_column_approx.sv
module amu_column_approx #(
    parameter int APPROX_COLS = 8
) (
    input  logic [31:0]            a,
    input  logic [31:0]            b,
    input  logic [APPROX_COLS-1:0] mask,
    output logic [63:0]            deficit
);
    localparam int CNT_W = 6;

    logic [63:0] col_def [APPROX_COLS];

    for (genvar j = 0; j < APPROX_COLS; j++) begin : g_col
        logic [CNT_W-1:0] ones;
        logic             any;
        always_comb begin
            ones = '0;
            any  = 1'b0;
            for (int i = 0; i <= j; i++) begin
                ones = ones + CNT_W'(a[i] & b[j-i]);
                any  = any | (a[i] & b[j-i]);
            end
            if (mask[j]) begin
                col_def[j] = '0;
            end else begin
                col_def[j] = (64'(ones) - 64'(any)) << j;
            end
        end
    end

    always_comb begin
        deficit = '0;
        for (int k = 0; k < APPROX_COLS; k++) begin
            deficit = deficit + col_def[k];
        end
    end
endmodule

// File: rtl/amu_product_core.sv
module amu_product_core
    import amu_pkg::*;
#(
    parameter int APPROX_COLS = 8
) (
    input  logic [31:0]            a,
    input  logic [31:0]            b,
    input  mul_op_e                op,
    input  logic                   approx_on,
    input  logic [APPROX_COLS-1:0] mask,
    output logic [31:0]            result
);
    logic        a_signed;
    logic        b_signed;
    logic [63:0] a_ext;
    logic [63:0] b_ext;
    logic [63:0] exact;
    logic [63:0] deficit;
    logic [63:0] lowered;

    amu_column_approx #(.APPROX_COLS(APPROX_COLS)) i_cols (
        .a       (a),
        .b       (b),
        .mask    (mask),
        .deficit (deficit)
    );

    always_comb begin
        a_signed = (op == OP_HI_SS) || (op == OP_HI_SU);
        b_signed = (op == OP_HI_SS);
        a_ext    = {{32{a_signed & a[31]}}, a};
        b_ext    = {{32{b_signed & b[31]}}, b};
        exact    = a_ext * b_ext;
        lowered  = approx_on ? (exact - deficit) : exact;
        result   = (op == OP_LO) ? lowered[31:0] : lowered[63:32];
    end
endmodule

// File: rtl/approx_mul_unit.sv
module approx_mul_unit
    import amu_pkg::*;
#(
    parameter int LATENCY     = 3,
    parameter int APPROX_COLS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [6:0]  opcode,
    input  logic [2:0]  funct3,
    input  logic [6:0]  funct7,
    input  logic [31:0] ctrl_word,
    input  logic [31:0] pc,
    input  logic [31:0] rs1,
    input  logic [31:0] rs2,
    output logic        busy,
    output logic [31:0] result
);
    localparam int CNT_W    = (LATENCY < 2) ? 1 : $clog2(LATENCY);
    localparam int MASK_LSB = 16;

    typedef struct packed {
        logic                   busy;
        logic [CNT_W-1:0]       cnt;
        mul_op_e                op;
        logic [31:0]            a;
        logic [31:0]            b;
        logic                   approx_on;
        logic [APPROX_COLS-1:0] mask;
        logic [31:0]            result;
    } state_t;

    state_t      st_d;
    state_t      st_q;
    logic        hit;
    mul_op_e     dec_op;
    logic        accept;
    logic [31:0] core_result;
    logic        unused_inputs;

    assign unused_inputs = ^{pc, ctrl_word};

    amu_decode i_decode (
        .opcode (opcode),
        .funct3 (funct3),
        .funct7 (funct7),
        .hit    (hit),
        .op     (dec_op)
    );

    amu_product_core #(.APPROX_COLS(APPROX_COLS)) i_core (
        .a         (st_q.a),
        .b         (st_q.b),
        .op        (st_q.op),
        .approx_on (st_q.approx_on),
        .mask      (st_q.mask),
        .result    (core_result)
    );

    always_comb begin
        st_d   = st_q;
        accept = hit && !st_q.busy;
        if (accept) begin
            st_d.busy      = 1'b1;
            st_d.cnt       = CNT_W'(LATENCY - 1);
            st_d.op        = dec_op;
            st_d.a         = rs1;
            st_d.b         = rs2;
            st_d.approx_on = ctrl_word[0] && (ctrl_word[2:1] == 2'b00);
            st_d.mask      = ctrl_word[MASK_LSB +: APPROX_COLS];
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy   = 1'b0;
                st_d.result = core_result;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = st_q.busy;
    assign result = st_q.result;

    AST_ACCEPT_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !busy) |=> busy); // R7
    AST_LAST_CYCLE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.cnt == '0) |=> !busy); // R7
    AST_RESULT_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.cnt != '0) |=> $stable(result)); // R8
    AST_RESULT_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(result)); // R8
    AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(st_q.a) && $stable(st_q.b) && $stable(st_q.mask))); // R9
endmodule

// File: tb/test_approx_mul_unit.sv
`timescale 1ns/1ps
module test_approx_mul_unit;
    localparam int LAT  = 4;
    localparam int COLS = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  opcode = '0;
    logic [2:0]  funct3 = '0;
    logic [6:0]  funct7 = '0;
    logic [31:0] ctrl_word = '0;
    logic [31:0] pc = '0;
    logic [31:0] rs1 = '0;
    logic [31:0] rs2 = '0;
    logic        busy;
    logic [31:0] result;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t sb[$];
    logic [31:0] last_val = '0;

    always #10 clk = ~clk;

    approx_mul_unit #(.LATENCY(LAT), .APPROX_COLS(COLS)) i_approx_mul_unit (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct3(funct3), .funct7(funct7),
        .ctrl_word(ctrl_word), .pc(pc), .rs1(rs1), .rs2(rs2), .busy(busy), .result(result)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_mul(input logic [2:0] f3, input logic [31:0] a,
                                            input logic [31:0] b, input logic [31:0] c);
        logic [63:0] ax;
        logic [63:0] bx;
        logic [63:0] p;
        logic [63:0] def;
        ax  = (f3 == 3'd1 || f3 == 3'd2) ? {{32{a[31]}}, a} : {32'b0, a};
        bx  = (f3 == 3'd1) ? {{32{b[31]}}, b} : {32'b0, b};
        p   = ax * bx;
        def = '0;
        if (c[0] && c[2:1] == 2'b00) begin
            for (int j = 0; j < COLS; j++) begin
                if (!c[16+j]) begin
                    int   n;
                    logic o;
                    n = 0;
                    o = 1'b0;
                    for (int i = 0; i <= j; i++) begin
                        n = n + int'(a[i] & b[j-i]);
                        o = o | (a[i] & b[j-i]);
                    end
                    def = def + ((64'(n) - 64'(o)) << j);
                end
            end
        end
        p = p - def;
        return (f3 == 3'd0) ? p[31:0] : p[63:32];
    endfunction

    // Driver: waits for idle, presents an operation, disturbs inputs while busy.
    task automatic issue(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c, input logic [31:0] exp, input string tag);
        @(negedge clk);
        while (busy) @(negedge clk);
        opcode = 7'b0110011; funct7 = 7'b0000001; funct3 = f3;
        rs1 = a; rs2 = b; ctrl_word = c;
        sb.push_back('{exp, tag});
        @(negedge clk);
        // R9: a different multiply with other operands while busy must be dropped
        funct3 = f3 ^ 3'd1; rs1 = ~a; rs2 = a ^ b ^ 32'h5A5A_0F0F; ctrl_word = ~c;
        while (busy) @(negedge clk);
        opcode = 7'b0000000; funct7 = 7'b0000000;
    endtask

    task automatic issue_ref(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b,
                             input logic [31:0] c, input string tag);
        issue(f3, a, b, c, ref_mul(f3, a, b, c), tag);
    endtask

    // Monitor: pops expected items as busy falls, checks busy length and held result.
    initial begin
        bit          prev_busy = 1'b0;
        int          run = 0;
        logic [31:0] held = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (busy) begin
                    if (!prev_busy) held = result;
                    run++;
                    check(result, held, "R8 result moved while busy");
                end else if (prev_busy) begin
                    check(32'(run), 32'(LAT), "R7 busy length");
                    run = 0;
                    if (sb.size() == 0) begin
                        errors++; checks++;
                        $display("FAIL R7 unexpected completion actual=%h expected=none", result);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(result, e.val, e.tag);
                        last_val = e.val;
                    end
                end
                prev_busy = busy;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check({31'b0, busy}, 32'd0, "R1 busy after reset");
        check(result, 32'd0, "R1 result after reset");
        rst_n = 1'b1;

        issue(3'd0, 32'd7, 32'd9, 32'h0, 32'd63, "R3 mul 7*9");
        issue_ref(3'd0, 32'hFFFF_FFFD, 32'd1000, 32'h0, "R3 mul negative");
        issue_ref(3'd1, 32'h8000_0000, 32'h8000_0000, 32'h0, "R4 mulh min*min");
        issue_ref(3'd1, 32'hFFFF_FFFF, 32'd5, 32'h0, "R4 mulh -1*5");
        issue_ref(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, "R5 mulhsu");
        issue_ref(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, "R6 mulhu");

        // R2: non-multiply codes are ignored
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            opcode = 7'b0110011; rs1 = 32'd3; rs2 = 32'd3;
            funct7 = (k == 0) ? 7'b0000000 : 7'b0000001;
            funct3 = (k == 0) ? 3'd0 : 3'd4;
            repeat (3) begin
                @(negedge clk);
                check({31'b0, busy}, 32'd0, "R2 ignored code busy");
                check(result, last_val, "R2 ignored code result");
            end
        end
        opcode = 7'b0000000;

        issue(3'd0, 32'd3, 32'd3, 32'h0000_0001, 32'd7, "R11 3*3 all columns approx");
        issue_ref(3'd0, 32'hFF, 32'hFF, 32'h0000_0001, "R11 0xFF squared mask clear");
        issue_ref(3'd0, 32'hFF, 32'hFF, 32'h0015_0001, "R11 partial mask");
        issue_ref(3'd3, 32'h0000_003F, 32'h0000_003F, 32'h0000_0001, "R11 high word mask clear");
        issue(3'd0, 32'hFF, 32'hFF, 32'h003F_0001, 32'h0000_FE01, "R12 full mask exact");
        issue(3'd0, 32'hFF, 32'hFF, 32'h0000_0003, 32'h0000_FE01, "R10 other circuit exact");
        issue(3'd0, 32'hFF, 32'hFF, 32'h0000_0000, 32'h0000_FE01, "R10 disabled exact");
        issue_ref(3'd1, 32'hFFFF_FF00, 32'h0000_00FF, 32'h0000_0001, "R11 signed approx");

        @(negedge clk);
        while (busy || sb.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        check(result, last_val, "R8 result held when idle");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule